// File: doc/BRIEF.md
# Reservation Station Pool with Result Bus Snooping

This block holds a small pool of reservation stations placed in front of one functional unit. An operation is issued into the lowest-numbered free station. Each of its two source registers is looked up in a register status table. If no producer is pending, the operand value supplied by the external register file is buffered. Otherwise the station keeps the producer's tag and waits.

Every station watches a single result bus. When a broadcast carries a tag that a station is waiting on, the station takes the value straight off the bus. Once both operands of a station are present it may be dispatched to the functional unit, lowest-numbered first. The unit later broadcasts the result with that station's tag, and the broadcast frees the station.

The status table records the tag of the youngest pending writer of each architectural register. The external register file is therefore written only by the producer that the table still names, so an older write can never overwrite a younger one. Tag 0 means "value present"; stations 0 to NRS-1 carry tags 1 to NRS.

Top module: `rs_pool`

## Requirements
- R1: `iss_ready` is high exactly when at least one station is free. A handshake (`iss_valid` with `iss_ready`) places the operation in the lowest-numbered free station, whose tag is its index plus one (tags 1..NRS, 0 = operand present).
- R2: When every station is busy, `iss_ready` is low and `iss_valid` has no effect on any station or status entry.
- R3: At issue, a source whose status entry is 0 takes `iss_val1`/`iss_val2`; otherwise it waits for the status tag. Every waiting station captures `cdb_data` when `cdb_valid` is high with a matching `cdb_tag`.
- R4: `fu_valid` is high only for a station whose two operands are both present and that has not yet been dispatched. `fu_a`/`fu_b` carry its source values in program order, and `fu_op`/`fu_tag` carry its operation and tag.
- R5: An issue in the same cycle as a broadcast of a source's producer tag takes the broadcast value and does not wait.
- R6: With several stations ready, the lowest-numbered one is dispatched. At most one dispatch happens per cycle, and each station is dispatched only once per issue.
- R7: A station that captures its last operand from a broadcast is dispatchable in the following cycle.
- R8: `rf_we` is high during a broadcast only if some register's status entry equals `cdb_tag`. In that case `rf_waddr` names that register, `rf_wdata` equals `cdb_data`, and the entry returns to 0.
- R9: Issue overwrites the destination's status entry with the new tag. A later reader waits for the youngest writer, and an older writer's broadcast does not update the register file.
- R10: A broadcast frees the station whose tag it carries, and that station can be issued again in the next cycle.
- R11: After reset all stations are free, all status entries are 0, and `fu_valid` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OPW | Operation code to store |
| iss_dst | input | RW | Destination architectural register |
| iss_src1 | input | RW | First source register |
| iss_src2 | input | RW | Second source register |
| iss_val1 | input | DW | Register file value of first source |
| iss_val2 | input | DW | Register file value of second source |
| iss_ready | output | 1 | A station is free |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TW | Tag of the producing station |
| cdb_data | input | DW | Result value |
| fu_valid | output | 1 | Dispatch to functional unit |
| fu_tag | output | TW | Tag of dispatched station |
| fu_op | output | OPW | Operation of dispatched station |
| fu_a | output | DW | First operand |
| fu_b | output | DW | Second operand |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | RW | Register file write address |
| rf_wdata | output | DW | Register file write data |

## Verification
Issue and result broadcast can land in the same cycle. That creates two overlaps: a new operation reading a register whose producer is being broadcast right then, and a broadcast that frees a station while the full pool refuses issue. Directed sequences arrange both overlaps on purpose, and the random phase produces them often. The bench keeps its own table of pending producers and station readiness, built from the requirements. From that table it predicts the dispatch tag, the operand values and every register file write, and at the end it compares the register file with the result of executing the operations in order.

// File: rtl/rs_pool.sv
`timescale 1ns/1ps
module rs_pool #(
  parameter int NRS  = 4,
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int OPW  = 2,
  localparam int TW  = $clog2(NRS + 1),
  localparam int RW  = $clog2(NREG),
  localparam int IW  = (NRS > 1) ? $clog2(NRS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  input  logic [OPW-1:0] iss_op,
  input  logic [RW-1:0]  iss_dst,
  input  logic [RW-1:0]  iss_src1,
  input  logic [RW-1:0]  iss_src2,
  input  logic [DW-1:0]  iss_val1,
  input  logic [DW-1:0]  iss_val2,
  output logic           iss_ready,
  input  logic           cdb_valid,
  input  logic [TW-1:0]  cdb_tag,
  input  logic [DW-1:0]  cdb_data,
  output logic           fu_valid,
  output logic [TW-1:0]  fu_tag,
  output logic [OPW-1:0] fu_op,
  output logic [DW-1:0]  fu_a,
  output logic [DW-1:0]  fu_b,
  output logic           rf_we,
  output logic [RW-1:0]  rf_waddr,
  output logic [DW-1:0]  rf_wdata
);

  logic [NRS-1:0] busy, sent, rdy;
  logic [OPW-1:0] op_q [NRS];
  logic [DW-1:0]  va [NRS];
  logic [DW-1:0]  vb [NRS];
  logic [TW-1:0]  ta [NRS];
  logic [TW-1:0]  tb [NRS];
  logic [TW-1:0]  stat [NREG];

  logic          free_hit;
  logic [IW-1:0] free_idx, disp_idx;
  logic [TW-1:0] st1, st2, src_t1, src_t2, new_tag;
  logic [DW-1:0] src_v1, src_v2;
  logic          byp1, byp2, do_issue, bus_hit;

  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = NRS - 1; i >= 0; i--)
      if (!busy[i]) begin
        free_hit = 1'b1;
        free_idx = IW'(i);
      end
  end

  for (genvar g = 0; g < NRS; g++) begin : g_rdy
    assign rdy[g] = busy[g] && !sent[g] && ta[g] == '0 && tb[g] == '0;
  end

  always_comb begin
    disp_idx = '0;
    for (int i = NRS - 1; i >= 0; i--)
      if (rdy[i]) disp_idx = IW'(i);
  end

  assign iss_ready = free_hit;
  assign do_issue  = iss_valid && free_hit;
  assign new_tag   = TW'(free_idx) + TW'(1);
  assign bus_hit   = cdb_valid && cdb_tag != '0;

  assign st1    = stat[iss_src1];
  assign st2    = stat[iss_src2];
  assign byp1   = bus_hit && st1 == cdb_tag;
  assign byp2   = bus_hit && st2 == cdb_tag;
  assign src_t1 = byp1 ? '0 : st1;
  assign src_t2 = byp2 ? '0 : st2;
  assign src_v1 = byp1 ? cdb_data : iss_val1;
  assign src_v2 = byp2 ? cdb_data : iss_val2;

  assign fu_valid = |rdy;
  assign fu_tag   = TW'(disp_idx) + TW'(1);
  assign fu_op    = op_q[disp_idx];
  assign fu_a     = va[disp_idx];
  assign fu_b     = vb[disp_idx];

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = '0;
    for (int r = 0; r < NREG; r++)
      if (bus_hit && stat[r] == cdb_tag) begin
        rf_we    = 1'b1;
        rf_waddr = RW'(r);
      end
  end
  assign rf_wdata = cdb_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      sent <= '0;
      for (int i = 0; i < NRS; i++) begin
        op_q[i] <= '0;
        va[i]   <= '0;
        vb[i]   <= '0;
        ta[i]   <= '0;
        tb[i]   <= '0;
      end
      for (int r = 0; r < NREG; r++) stat[r] <= '0;
    end else begin
      for (int i = 0; i < NRS; i++) begin
        if (bus_hit && busy[i]) begin
          if (ta[i] == cdb_tag) begin
            ta[i] <= '0;
            va[i] <= cdb_data;
          end
          if (tb[i] == cdb_tag) begin
            tb[i] <= '0;
            vb[i] <= cdb_data;
          end
          if (cdb_tag == TW'(i + 1)) begin
            busy[i] <= 1'b0;
            sent[i] <= 1'b0;
          end
        end
        if (fu_valid && disp_idx == IW'(i)) sent[i] <= 1'b1;
      end
      for (int r = 0; r < NREG; r++)
        if (bus_hit && stat[r] == cdb_tag) stat[r] <= '0;
      if (do_issue) begin
        busy[free_idx] <= 1'b1;
        sent[free_idx] <= 1'b0;
        op_q[free_idx] <= iss_op;
        ta[free_idx]   <= src_t1;
        tb[free_idx]   <= src_t2;
        va[free_idx]   <= src_v1;
        vb[free_idx]   <= src_v2;
        stat[iss_dst]  <= new_tag;
      end
    end
  end

endmodule

// File: rtl/rs_pool_chk.sv
`timescale 1ns/1ps
module rs_pool_chk #(
  parameter int NRS = 4,
  parameter int TW  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_ready,
  input logic          cdb_valid,
  input logic          fu_valid,
  input logic [TW-1:0] fu_tag,
  input logic          rf_we
);

  a_r6_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid |-> (fu_tag != '0 && int'(fu_tag) <= NRS));

  a_r6_one_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    fu_valid |=> !(fu_valid && fu_tag == $past(fu_tag)));

  a_r8_write_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> cdb_valid);

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && !iss_ready) |=> iss_ready);

endmodule

bind rs_pool rs_pool_chk #(.NRS(NRS), .TW(TW)) u_rs_pool_chk (
  .clk(clk), .rst_n(rst_n), .iss_ready(iss_ready), .cdb_valid(cdb_valid),
  .fu_valid(fu_valid), .fu_tag(fu_tag), .rf_we(rf_we)
);

// File: tb/test_rs_pool.sv
`timescale 1ns/1ps
module test_rs_pool;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, cdb_valid = 0;
  logic [1:0] iss_op = 0;
  logic [2:0] iss_dst = 0, iss_src1 = 0, iss_src2 = 0, cdb_tag = 0;
  logic [31:0] iss_val1 = 0, iss_val2 = 0, cdb_data = 0;
  logic iss_ready, fu_valid, rf_we;
  logic [2:0] fu_tag, rf_waddr;
  logic [1:0] fu_op;
  logic [31:0] fu_a, fu_b, rf_wdata;

  rs_pool i_rs_pool (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, last_tag = 0;
  logic [31:0] brf [8], aref [8];
  logic [2:0] mstat [8];
  bit mbusy [5], mdisp [5], pend [5];
  logic [2:0] mt1 [5], mt2 [5];
  logic [31:0] ea [5], eb [5], eres [5];

  function automatic logic [31:0] alu(input logic [1:0] op, input logic [31:0] a, b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a ^ b;
      default: return a | b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // mode: 0 no broadcast, 1 broadcast tag bt, 2 random, 3 always when possible
  task automatic step(input bit want, input logic [1:0] op, input logic [2:0] d, s1, s2,
                      input int mode, input int bt_in);
    int free_t, rdy_t, bt, start;
    bit do_bc, exp_we;
    logic [2:0] exp_wa;
    free_t = 0;
    for (int t = 4; t >= 1; t--) if (!mbusy[t]) free_t = t;
    chk(iss_ready == (free_t != 0), "R1 R2 iss_ready", 32'(iss_ready), 32'(free_t != 0));
    rdy_t = 0;
    for (int t = 4; t >= 1; t--)
      if (mbusy[t] && !mdisp[t] && mt1[t] == 0 && mt2[t] == 0) rdy_t = t;
    chk(fu_valid == (rdy_t != 0), "R4 fu_valid", 32'(fu_valid), 32'(rdy_t != 0));
    if (fu_valid && rdy_t != 0) begin
      chk(fu_tag == 3'(rdy_t), "R6 fu_tag", 32'(fu_tag), 32'(rdy_t));
      chk(fu_a == ea[rdy_t], "R3 fu_a", fu_a, ea[rdy_t]);
      chk(fu_b == eb[rdy_t], "R3 fu_b", fu_b, eb[rdy_t]);
    end
    do_bc = 0; bt = 0;
    if (mode == 1) begin
      bt = bt_in; do_bc = pend[bt];
    end else if (mode == 3 || (mode == 2 && $urandom % 100 < 60)) begin
      start = $urandom % 4;
      for (int k = 0; k < 4; k++)
        if (!do_bc && pend[1 + (start + k) % 4]) begin
          do_bc = 1; bt = 1 + (start + k) % 4;
        end
    end
    iss_valid = want; iss_op = op; iss_dst = d; iss_src1 = s1; iss_src2 = s2;
    iss_val1 = brf[s1]; iss_val2 = brf[s2];
    cdb_valid = do_bc; cdb_tag = 3'(bt); cdb_data = do_bc ? eres[bt] : 32'hdead_beef;
    #1;
    exp_we = 0; exp_wa = 0;
    for (int r = 0; r < 8; r++)
      if (do_bc && mstat[r] == 3'(bt)) begin exp_we = 1; exp_wa = 3'(r); end
    chk(rf_we == exp_we, "R8 rf_we", 32'(rf_we), 32'(exp_we));
    if (exp_we) begin
      chk(rf_waddr == exp_wa, "R8 rf_waddr", 32'(rf_waddr), 32'(exp_wa));
      chk(rf_wdata == eres[bt], "R8 rf_wdata", rf_wdata, eres[bt]);
      brf[exp_wa] = eres[bt];
    end
    if (do_bc) begin
      pend[bt] = 0; mbusy[bt] = 0; mdisp[bt] = 0;
      for (int t = 1; t <= 4; t++) begin
        if (mbusy[t] && mt1[t] == 3'(bt)) mt1[t] = 0;
        if (mbusy[t] && mt2[t] == 3'(bt)) mt2[t] = 0;
      end
      for (int r = 0; r < 8; r++) if (mstat[r] == 3'(bt)) mstat[r] = 0;
    end
    if (rdy_t != 0) begin mdisp[rdy_t] = 1; pend[rdy_t] = 1; end
    if (want && free_t != 0) begin
      mbusy[free_t] = 1; mdisp[free_t] = 0;
      mt1[free_t] = mstat[s1]; mt2[free_t] = mstat[s2];
      ea[free_t] = aref[s1]; eb[free_t] = aref[s2];
      eres[free_t] = alu(op, aref[s1], aref[s2]);
      aref[d] = eres[free_t];
      mstat[d] = 3'(free_t);
      last_tag = free_t;
    end
    @(posedge clk);
    @(negedge clk);
    iss_valid = 0; cdb_valid = 0;
  endtask

  task automatic drain();
    int n;
    bit idle;
    n = 0;
    idle = 0;
    while (!idle && n < 300) begin
      idle = 1;
      for (int t = 1; t <= 4; t++) if (mbusy[t]) idle = 0;
      if (!idle) step(0, 0, 0, 0, 0, 3, 0);
      n++;
    end
    chk(idle, "R10 drain", 32'(idle), 32'd1);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int s, first;
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) begin
      brf[r] = 32'h1111 * (r + 1); aref[r] = brf[r]; mstat[r] = 0;
    end
    for (int t = 0; t < 5; t++) begin mbusy[t] = 0; mdisp[t] = 0; pend[t] = 0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(iss_ready == 1, "R11 iss_ready", 32'(iss_ready), 1);
    chk(fu_valid == 0, "R11 fu_valid", 32'(fu_valid), 0);
    chk(rf_we == 0, "R11 rf_we", 32'(rf_we), 0);
    rst_n = 1;
    @(negedge clk);

    // R6 R7: two stations woken by one broadcast
    step(1, 0, 1, 2, 3, 0, 0);
    first = last_tag;
    step(1, 1, 4, 1, 1, 0, 0);
    step(1, 2, 5, 1, 2, 0, 0);
    step(0, 0, 0, 0, 0, 1, first);
    chk(fu_valid && fu_tag == 3'd2, "R7 wake dispatch", 32'(fu_tag), 32'd2);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(fu_valid && fu_tag == 3'd3, "R6 second wake", 32'(fu_tag), 32'd3);
    drain();

    // R5 issue during producer broadcast
    step(1, 0, 1, 2, 3, 0, 0);
    first = last_tag;
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 3, 6, 1, 1, 1, first);
    chk(fu_valid && fu_tag == 3'(last_tag), "R5 bypass dispatch", 32'(fu_tag), 32'(last_tag));
    drain();

    // R9: younger writer broadcast first, older writer later
    step(1, 0, 7, 1, 2, 0, 0);
    first = last_tag;
    step(1, 2, 7, 2, 3, 0, 0);
    s = last_tag;
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, s);
    step(0, 0, 0, 0, 0, 1, first);
    chk(rf_we == 0, "R9 no stale write", 32'(rf_we), 0);
    drain();
    chk(brf[7] == aref[7], "R9 youngest kept", brf[7], aref[7]);

    // R2 R10: fill the pool, try to issue, then release one station
    step(1, 0, 1, 2, 3, 0, 0);
    first = last_tag;
    step(1, 1, 2, 1, 2, 0, 0);
    step(1, 1, 3, 1, 3, 0, 0);
    step(1, 1, 4, 1, 4, 0, 0);
    chk(iss_ready == 0, "R2 full", 32'(iss_ready), 0);
    step(1, 3, 5, 5, 5, 0, 0);
    step(1, 3, 5, 6, 6, 1, first);
    chk(iss_ready == 1, "R10 freed", 32'(iss_ready), 1);
    step(1, 2, 6, 6, 6, 0, 0);
    chk(last_tag == first, "R10 reuse", 32'(last_tag), 32'(first));
    drain();

    for (int n = 0; n < 4000; n++)
      step($urandom % 100 < 70, 2'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 2, 0);
    drain();
    for (int r = 0; r < 8; r++)
      chk(brf[r] == aref[r], "R3 R9 final register", brf[r], aref[r]);
    finish_run();
  end
endmodule